// File: doc/BRIEF.md
# Strided Banked Vector Load-Store Unit

This block moves one vector between a word memory split into independently addressed banks and a local vector register buffer. A command gives a word base address, a signed stride and an element count. The unit walks the strided address sequence and issues at most one word access per clock. Each access goes to the bank picked by the low address bits and carries the rest of the address on that bank's own address slot. Loads write the returned words into consecutive buffer elements. Stores send consecutive buffer elements out to memory.

Memory read data comes back a fixed number of cycles after the access is issued. The unit tracks each outstanding load in a shift pipeline, so it needs no tags. A bank that was accessed on the previous cycle is still busy. If the next element maps to that bank, issue waits one cycle and element order is kept. A host port writes and reads the buffer while the unit is idle.

Control is one state machine with four states. ST_IDLE waits for a command. ST_ISSUE generates accesses. ST_DRAIN waits for outstanding load data. ST_FINISH raises done for one cycle. The transitions are:
- ST_IDLE to ST_ISSUE on an accepted start with a non-zero length.
- ST_IDLE to ST_FINISH on an accepted start with length zero.
- ST_ISSUE to ST_FINISH when the last store element is issued.
- ST_ISSUE to ST_DRAIN when the last load element is issued.
- ST_DRAIN to ST_FINISH when the last load data is written.
- ST_FINISH to ST_IDLE always.

Top module: `vec_ldst_unit`

## Requirements
- R1: During and after reset the unit is idle: busy, done and every bank enable are low.
- R2: Element i uses word address (base + i*stride) modulo 2^ADDR_W. The stride is a two's-complement word count, so negative strides walk downward and wrap.
- R3: The bank of an access is the low 3 address bits, and at most one bank enable is high in any cycle. The enabled bank's slot of bank_addr (bits b*(ADDR_W-3) upward) carries the address with those 3 bits removed.
- R4: Without bank conflicts, element 0 is issued in the cycle after start is sampled, and each later element is issued in the following cycle, in element order.
- R5: For a load, the word on the issued bank's bank_rdata slot 4 cycles after the issue cycle is written to buffer element i. bank_we is low on load accesses. host_rdata shows element host_idx.
- R6: If element i maps to the same bank as element i-1, it is issued two cycles after element i-1 instead of one. Element order is unchanged.
- R7: For a store, bank_we is high during each access and bank_wdata carries buffer element i.
- R8: done is a one-cycle pulse. For a store it comes in the cycle after the last issue. For a load it comes in the cycle after the last data is written, which is 5 cycles after the last issue.
- R9: A length of 0 raises done in the cycle after start with no bank access.
- R10: A length above MAX_VL moves exactly MAX_VL elements.
- R11: busy is high from the cycle after start until done. A start while busy is ignored.
- R12: A host write takes effect only while idle. A host write while busy leaves the buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command strobe, sampled when idle |
| is_store | input | 1 | 1 = store buffer to memory, 0 = load |
| base_addr | input | ADDR_W | Word address of element 0 |
| stride | input | STRIDE_W | Signed word distance between elements |
| vec_len | input | $clog2(MAX_VL+1) | Element count |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| bank_en | output | NUM_BANKS | Per-bank access enable |
| bank_we | output | 1 | Write strobe for the enabled bank |
| bank_addr | output | NUM_BANKS*(ADDR_W-3) | Per-bank word address slots |
| bank_wdata | output | DATA_W | Store data |
| bank_rdata | input | NUM_BANKS*DATA_W | Per-bank read data, valid 4 cycles after issue |
| host_we | input | 1 | Buffer write strobe, honoured when idle |
| host_idx | input | $clog2(MAX_VL) | Buffer element index for host access |
| host_wdata | input | DATA_W | Buffer write data |
| host_rdata | output | DATA_W | Buffer element at host_idx |

## Verification
The bench builds the unit with ADDR_W=10 and MAX_VL=16, keeping DATA_W=32, a 16-bit stride, 8 banks, latency 4 and bank busy time 2. The 1024-word space makes wrap-around in both stride directions easy to reach. The 16-element buffer lets an over-long length show clamping, and lets every buffer element be read back after each load. Strides of 8 and 0 force a conflict on every element, while strides of 1, 3 and -3 spread accesses across banks.

// File: rtl/vls_pkg.sv
package vls_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_DRAIN  = 2'd2,
        ST_FINISH = 2'd3
    } vls_state_e;

endpackage

// File: rtl/vls_addr_gen.sv
module vls_addr_gen #(
    parameter int ADDR_W   = 16,
    parameter int STRIDE_W = 16,
    parameter int LEN_W    = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                advance,
    input  logic [ADDR_W-1:0]   base_in,
    input  logic [STRIDE_W-1:0] stride_in,
    input  logic [LEN_W-1:0]    len_in,
    output logic [ADDR_W-1:0]   addr,
    output logic [LEN_W-1:0]    elem_idx,
    output logic [LEN_W-1:0]    len_q,
    output logic                at_last
);
    localparam int SUM_W = (ADDR_W > STRIDE_W) ? ADDR_W : STRIDE_W;

    logic [STRIDE_W-1:0] stride_q;
    logic [SUM_W-1:0]    stride_ext;
    logic [SUM_W-1:0]    addr_ext;
    logic [ADDR_W-1:0]   addr_next;

    // sign-extend the stride, add, keep the low ADDR_W bits (wraps)
    assign stride_ext = SUM_W'($signed(stride_q));
    assign addr_ext   = SUM_W'(addr);
    assign addr_next  = ADDR_W'(addr_ext + stride_ext);
    assign at_last    = (elem_idx == len_q - LEN_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr     <= '0;
            elem_idx <= '0;
            len_q    <= '0;
            stride_q <= '0;
        end else if (load) begin
            addr     <= base_in;
            elem_idx <= '0;
            len_q    <= len_in;
            stride_q <= stride_in;
        end else if (advance) begin
            addr     <= addr_next;
            elem_idx <= elem_idx + LEN_W'(1);
        end
    end

    // R10: the element counter never runs past the captured length
    a_r10_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        elem_idx <= len_q)
        else $error("element index beyond length");

endmodule

// File: rtl/vls_bank_track.sv
module vls_bank_track #(
    parameter int NB       = 8,
    parameter int BUSY_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] issue_en,
    output logic [NB-1:0] busy_vec
);
    localparam int CNT_W = (BUSY_CYC > 1) ? $clog2(BUSY_CYC) : 1;

    for (genvar gb = 0; gb < NB; gb++) begin : g_bank
        logic [CNT_W-1:0] cnt;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt <= '0;
            end else if (issue_en[gb]) begin
                cnt <= CNT_W'(BUSY_CYC - 1);
            end else if (cnt != '0) begin
                cnt <= cnt - CNT_W'(1);
            end
        end

        assign busy_vec[gb] = (cnt != '0);

        if (BUSY_CYC > 1) begin : g_chk
            // R6: a bank is never accessed on two consecutive cycles
            a_r6_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
                issue_en[gb] |=> !issue_en[gb])
                else $error("bank %0d accessed while busy", gb);
        end
    end

endmodule

// File: rtl/vls_ret_pipe.sv
module vls_ret_pipe #(
    parameter int LAT    = 4,
    parameter int IDX_W  = 6,
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [IDX_W-1:0]  push_idx,
    input  logic [BANK_W-1:0] push_bank,
    output logic              ret_valid,
    output logic [IDX_W-1:0]  ret_idx,
    output logic [BANK_W-1:0] ret_bank
);
    logic [LAT-1:0]    vld;
    logic [IDX_W-1:0]  idx_q  [LAT];
    logic [BANK_W-1:0] bank_q [LAT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            vld[0] <= push;
            for (int s = 1; s < LAT; s++) begin
                vld[s] <= vld[s-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        idx_q[0]  <= push_idx;
        bank_q[0] <= push_bank;
        for (int s = 1; s < LAT; s++) begin
            idx_q[s]  <= idx_q[s-1];
            bank_q[s] <= bank_q[s-1];
        end
    end

    assign ret_valid = vld[LAT-1];
    assign ret_idx   = idx_q[LAT-1];
    assign ret_bank  = bank_q[LAT-1];

    // R5: back-to-back returns belong to consecutive elements
    a_r5_in_order: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && $past(ret_valid)) |-> (ret_idx == IDX_W'($past(ret_idx) + 1'b1)))
        else $error("load data returned out of element order");

endmodule

// File: rtl/vls_vreg.sv
module vls_vreg #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              wa_en,
    input  logic [IDX_W-1:0]  wa_idx,
    input  logic [DATA_W-1:0] wa_data,
    input  logic              wb_en,
    input  logic [IDX_W-1:0]  wb_idx,
    input  logic [DATA_W-1:0] wb_data,
    input  logic [IDX_W-1:0]  ra_idx,
    output logic [DATA_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [DATA_W-1:0] rb_data
);
    logic [DATA_W-1:0] elems [DEPTH];

    always_ff @(posedge clk) begin
        if (wa_en) begin
            elems[wa_idx] <= wa_data;
        end else if (wb_en) begin
            elems[wb_idx] <= wb_data;
        end
    end

    assign ra_data = elems[ra_idx];
    assign rb_data = elems[rb_idx];

endmodule

// File: rtl/vec_ldst_unit.sv
module vec_ldst_unit #(
    parameter int NUM_BANKS = 8,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int STRIDE_W  = 16,
    parameter int MAX_VL    = 64,
    parameter int LATENCY   = 4,
    parameter int BANK_BUSY = 2,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int BAW      = ADDR_W - BANK_W,
    localparam int LEN_W    = $clog2(MAX_VL + 1),
    localparam int IDX_W    = $clog2(MAX_VL)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     is_store,
    input  logic [ADDR_W-1:0]        base_addr,
    input  logic [STRIDE_W-1:0]      stride,
    input  logic [LEN_W-1:0]         vec_len,
    output logic                     busy,
    output logic                     done,
    output logic [NUM_BANKS-1:0]     bank_en,
    output logic                     bank_we,
    output logic [NUM_BANKS*BAW-1:0] bank_addr,
    output logic [DATA_W-1:0]        bank_wdata,
    input  logic [NUM_BANKS*DATA_W-1:0] bank_rdata,
    input  logic                     host_we,
    input  logic [IDX_W-1:0]         host_idx,
    input  logic [DATA_W-1:0]        host_wdata,
    output logic [DATA_W-1:0]        host_rdata
);
    import vls_pkg::*;

    vls_state_e state, state_nx;
    logic op_store;

    logic [LEN_W-1:0]     len_clamped;
    logic                 accept;
    logic [ADDR_W-1:0]    cur_addr;
    logic [LEN_W-1:0]     elem_idx;
    logic [LEN_W-1:0]     len_q;
    logic                 at_last;
    logic [BANK_W-1:0]    cur_bank;
    logic [NUM_BANKS-1:0] busy_vec;
    logic                 stall;
    logic                 issue;
    logic                 ret_valid;
    logic [IDX_W-1:0]     ret_idx;
    logic [BANK_W-1:0]    ret_bank;
    logic                 ret_last;
    logic [DATA_W-1:0]    ret_data;
    logic [DATA_W-1:0]    store_data;

    assign len_clamped = (vec_len > LEN_W'(MAX_VL)) ? LEN_W'(MAX_VL) : vec_len;
    assign accept      = (state == ST_IDLE) && start;
    assign cur_bank    = cur_addr[BANK_W-1:0];
    assign stall       = busy_vec[cur_bank];
    assign issue       = (state == ST_ISSUE) && !stall;
    assign ret_last    = (LEN_W'(ret_idx) == len_q - LEN_W'(1));
    assign ret_data    = bank_rdata[ret_bank*DATA_W +: DATA_W];

    vls_addr_gen #(
        .ADDR_W   (ADDR_W),
        .STRIDE_W (STRIDE_W),
        .LEN_W    (LEN_W)
    ) u_agen (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .advance   (issue),
        .base_in   (base_addr),
        .stride_in (stride),
        .len_in    (len_clamped),
        .addr      (cur_addr),
        .elem_idx  (elem_idx),
        .len_q     (len_q),
        .at_last   (at_last)
    );

    vls_bank_track #(
        .NB       (NUM_BANKS),
        .BUSY_CYC (BANK_BUSY)
    ) u_btrack (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue_en (bank_en),
        .busy_vec (busy_vec)
    );

    vls_ret_pipe #(
        .LAT    (LATENCY),
        .IDX_W  (IDX_W),
        .BANK_W (BANK_W)
    ) u_rpipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (issue && !op_store),
        .push_idx  (IDX_W'(elem_idx)),
        .push_bank (cur_bank),
        .ret_valid (ret_valid),
        .ret_idx   (ret_idx),
        .ret_bank  (ret_bank)
    );

    vls_vreg #(
        .DEPTH  (MAX_VL),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_vreg (
        .clk     (clk),
        .wa_en   (ret_valid),
        .wa_idx  (ret_idx),
        .wa_data (ret_data),
        .wb_en   (host_we && (state == ST_IDLE)),
        .wb_idx  (host_idx),
        .wb_data (host_wdata),
        .ra_idx  (IDX_W'(elem_idx)),
        .ra_data (store_data),
        .rb_idx  (host_idx),
        .rb_data (host_rdata)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            op_store <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                op_store <= is_store;
            end
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    state_nx = (len_clamped == '0) ? ST_FINISH : ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (issue && at_last) begin
                    state_nx = op_store ? ST_FINISH : ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (ret_valid && ret_last) begin
                    state_nx = ST_FINISH;
                end
            end
            ST_FINISH: begin
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy    = (state != ST_IDLE);
        done    = (state == ST_FINISH);
        bank_we = issue && op_store;
        bank_en = '0;
        if (issue) begin
            bank_en[cur_bank] = 1'b1;
        end
    end

    assign bank_wdata = store_data;

    for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_baddr
        assign bank_addr[gb*BAW +: BAW] =
            bank_en[gb] ? cur_addr[ADDR_W-1:BANK_W] : '0;
    end

    // R3: one bank per cycle at most
    a_r3_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_en))
        else $error("more than one bank enabled");

    // R8: completion is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done held for more than one cycle");

endmodule

// File: tb/vec_ldst_unit_bench.sv
module vec_ldst_unit_bench;

    localparam int NB   = 8;
    localparam int AW   = 10;
    localparam int DW   = 32;
    localparam int SW   = 16;
    localparam int MAXV = 16;
    localparam int LW   = $clog2(MAXV + 1);
    localparam int IW   = $clog2(MAXV);
    localparam int BAW  = AW - 3;
    localparam int MSZ  = 1 << AW;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic                is_store = 1'b0;
    logic [AW-1:0]       base_addr = '0;
    logic [SW-1:0]       stride = '0;
    logic [LW-1:0]       vec_len = '0;
    logic                busy, done, bank_we;
    logic [NB-1:0]       bank_en;
    logic [NB*BAW-1:0]   bank_addr;
    logic [DW-1:0]       bank_wdata;
    logic [NB*DW-1:0]    bank_rdata;
    logic                host_we = 1'b0;
    logic [IW-1:0]       host_idx = '0;
    logic [DW-1:0]       host_wdata = '0;
    logic [DW-1:0]       host_rdata;

    vec_ldst_unit #(
        .NUM_BANKS (NB), .ADDR_W (AW), .DATA_W (DW), .STRIDE_W (SW),
        .MAX_VL (MAXV), .LATENCY (4), .BANK_BUSY (2)
    ) u_vec_ldst_unit (
        .clk (clk), .rst_n (rst_n), .start (start), .is_store (is_store),
        .base_addr (base_addr), .stride (stride), .vec_len (vec_len),
        .busy (busy), .done (done), .bank_en (bank_en), .bank_we (bank_we),
        .bank_addr (bank_addr), .bank_wdata (bank_wdata), .bank_rdata (bank_rdata),
        .host_we (host_we), .host_idx (host_idx), .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    // environment memory with 4-cycle read latency
    logic [DW-1:0] mem [MSZ];
    logic [3:0]    rv;
    logic [2:0]    rb [4];
    logic [DW-1:0] rd [4];

    always @(posedge clk) begin
        logic          ld;
        logic [2:0]    lb;
        logic [DW-1:0] ldat;
        ld = 1'b0; lb = '0; ldat = '0;
        for (int b = 0; b < NB; b++) begin
            if (rst_n && bank_en[b]) begin
                int a;
                a = int'(bank_addr[b*BAW +: BAW]) * 8 + b;
                if (bank_we) mem[a] <= bank_wdata;
                else begin ld = 1'b1; lb = 3'(b); ldat = mem[a]; end
            end
        end
        rv <= {rv[2:0], ld};
        rb[0] <= lb; rd[0] <= ldat;
        for (int s = 1; s < 4; s++) begin rb[s] <= rb[s-1]; rd[s] <= rd[s-1]; end
    end

    always_comb begin
        for (int b = 0; b < NB; b++) bank_rdata[b*DW +: DW] = 32'hDEAD_BEEF;
        if (rv[3]) bank_rdata[int'(rb[3])*DW +: DW] = rd[3];
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog: got %0d expected 0", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    // reference state
    logic [DW-1:0] vbuf     [MAXV];
    logic [DW-1:0] exp_vbuf [MAXV];
    logic [DW-1:0] exp_mem  [MSZ];
    int exp_a [MAXV];
    int exp_t [MAXV];

    task automatic host_write(int idx, logic [DW-1:0] v);
        @(negedge clk);
        host_we = 1'b1; host_idx = IW'(idx); host_wdata = v;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic run_op(bit st, int base, int strd, int len, bit poke_start, bit poke_host);
        int eff, dcyc;
        eff = (len > MAXV) ? MAXV : len;
        for (int i = 0; i < eff; i++) begin
            exp_a[i] = (((base + i * strd) % MSZ) + MSZ) % MSZ;
            if (i == 0) exp_t[i] = 1;
            else exp_t[i] = exp_t[i-1] + 1 + (((exp_a[i] % 8) == (exp_a[i-1] % 8)) ? 1 : 0);
        end
        if (eff == 0) dcyc = 1;
        else dcyc = st ? exp_t[eff-1] + 1 : exp_t[eff-1] + 5;
        for (int a = 0; a < MSZ; a++) exp_mem[a] = mem[a];
        for (int i = 0; i < MAXV; i++) exp_vbuf[i] = vbuf[i];
        for (int i = 0; i < eff; i++) begin
            if (st) exp_mem[exp_a[i]] = vbuf[i];
            else exp_vbuf[i] = mem[exp_a[i]];
        end

        @(negedge clk);
        start = 1'b1; is_store = st; base_addr = AW'(base);
        stride = SW'(strd); vec_len = LW'(len);
        for (int c = 1; c <= dcyc + 2; c++) begin
            int ei;
            logic [NB-1:0] een;
            @(negedge clk);
            if (c == 1) start = 1'b0;
            ei = -1; een = '0;
            for (int i = 0; i < eff; i++) if (exp_t[i] == c) ei = i;
            if (ei >= 0) een[exp_a[ei] % 8] = 1'b1;
            chk((eff == 0) ? "R9" : "R8", "done", done, (c == dcyc));
            chk("R11", "busy", busy, (c <= dcyc));
            chk((eff == 0) ? "R9" : "R4/R6", "bank_en", bank_en, een);
            if (ei >= 0) begin
                chk("R2/R3", "bank_addr", bank_addr[(exp_a[ei] % 8)*BAW +: BAW], exp_a[ei] / 8);
                chk(st ? "R7" : "R5", "bank_we", bank_we, st);
                if (st) chk("R7", "bank_wdata", bank_wdata, vbuf[ei]);
            end
            if (poke_start && c == 2) begin
                start = 1'b1; is_store = !st; vec_len = LW'(3); base_addr = AW'(7);
            end
            if (poke_host && c == 2) begin
                host_we = 1'b1; host_idx = IW'(1); host_wdata = 32'h0000_0BAD;
            end
            if (c == 3) begin start = 1'b0; host_we = 1'b0; end
        end
        if (st) begin
            int bad;
            bad = 0;
            for (int a = 0; a < MSZ; a++) if (mem[a] !== exp_mem[a]) bad++;
            chk("R7", "memory words differing", bad, 0);
        end
        for (int i = 0; i < MAXV; i++) begin
            host_idx = IW'(i);
            #1;
            chk(poke_host ? "R12" : (len > MAXV ? "R10" : "R5"), "buffer element", host_rdata, exp_vbuf[i]);
            vbuf[i] = exp_vbuf[i];
        end
    endtask

    initial begin
        for (int a = 0; a < MSZ; a++) mem[a] = 32'hA500_0000 + a * 32'h0001_0003;
        for (int s = 0; s < 4; s++) begin rb[s] = '0; rd[s] = '0; end
        rv = '0;
        // R1: reset state
        repeat (2) @(negedge clk);
        chk("R1", "busy in reset", busy, 0);
        chk("R1", "done in reset", done, 0);
        chk("R1", "bank_en in reset", bank_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy after reset", busy, 0);
        chk("R1", "bank_en after reset", bank_en, 0);
        // R12: idle host writes land in the buffer
        for (int i = 0; i < MAXV; i++) begin
            vbuf[i] = 32'h1000_0000 + i * 32'h0000_0111;
            host_write(i, vbuf[i]);
        end
        for (int i = 0; i < MAXV; i++) begin
            host_idx = IW'(i);
            #1;
            chk("R12", "preload readback", host_rdata, vbuf[i]);
        end
        run_op(1'b1, 0, 1, 8, 1'b0, 1'b0);      // R4 R7 unit-stride store
        run_op(1'b0, 0, 1, 8, 1'b1, 1'b0);      // R5 R11 load with ignored start
        run_op(1'b0, 5, 8, 5, 1'b0, 1'b0);      // R6 every element same bank
        run_op(1'b1, 2, -3, 10, 1'b0, 1'b1);    // R2 negative wrap, R12 busy host write
        run_op(1'b0, 300, 0, 3, 1'b0, 1'b0);    // R6 zero stride
        run_op(1'b1, 40, 1, 0, 1'b0, 1'b0);     // R9 empty vector
        run_op(1'b0, 100, 9, 20, 1'b0, 1'b0);   // R10 clamped length
        run_op(1'b0, 1000, 3, 16, 1'b0, 1'b0);  // R2 upward wrap
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule